// File: doc/BRIEF.md
# Hardware Breakpoint Match Unit

This block watches every instruction fetch and every data access a processor core presents, and compares each one against four programmable linear addresses. When an enabled breakpoint slot matches, it raises a request to the exception logic. Instruction matches are reported as a fault in the same cycle as the fetch, before the instruction runs. Data matches are reported as a trap when the instruction retires.

Each slot has its own address and two fields: a length field (1, 2 or 4 bytes) and an access-type qualifier. Each slot is enabled by a global bit or by a local bit. The local bits and the local exact-report bit are cleared by a task-switch pulse. A guard bit blocks every register access with a fault until the exception logic signals, by an entry pulse, that the debug handler has begun. A status register records which slots matched, whether or not each slot was enabled.

Software reaches the registers through a simple select/strobe port. The core drives a fetch monitor port, a data monitor port and a retire pulse. The exception and task logic drive the task-switch and handler-entry pulses.

Top module: `bkpt_unit`

## Requirements
- R1: After reset, every register reads as zero. `exec_fault`, `data_trap` and `reg_fault` are low.
- R2: The register select map is: selects 0 to 3 are the slot addresses, select 4 is the control word and select 5 is the status word. A write with `reg_en`, `reg_wr` high takes effect at the clock edge. A read returns the value on `reg_rdata` in the same cycle. Any other select reads as zero.
- R3: A slot whose qualifier is 00 (execute) raises `exec_fault` in the same cycle as `fetch_valid` when `fetch_addr` equals its address exactly. The slot's length field is ignored for execute matches. Execute slots never match data accesses.
- R4: For data matches, the length code is 00 for 1 byte, 01 for 2 bytes and 1x for 4 bytes. The access size `mem_size` uses the same codes, and accesses are naturally aligned. A slot matches when the aligned region of its address overlaps the region of the access.
- R5: For data accesses, qualifier 01 matches writes only and qualifier 11 matches reads and writes. Qualifiers 10 and 00 never match a data access.
- R6: Control bit i (0 to 3) is the local enable of slot i, and bit 4+i is its global enable. A slot raises a request only when at least one of its two enables is set.
- R7: Status bit i is set by any match of slot i, even when the slot is disabled. The bit stays set until software writes 0 to it. Writing 1 to a status bit neither sets nor clears it.
- R8: While control bit 13 (guard) is set, every register access raises `reg_fault`. The access reads zero and a write to it is ignored. An `exc_entry` pulse clears the guard bit.
- R9: A `task_sw` pulse clears control bits 0 to 3 and bit 8 (local exact). It keeps bits 4 to 7 and bit 9 (global exact).
- R10: When control bit 8 or bit 9 is set, a data match raises `data_trap` on the `retire` pulse that ends the instruction making the access. When both bits are clear, the trap comes on the retire pulse after that one.
- R11: Control bits 17:16+2i are slot i's qualifier, and bits 25:24+2i are its length code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_en | input | 1 | Register access strobe |
| reg_wr | input | 1 | 1 = write, 0 = read |
| reg_sel | input | 3 | Register select |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid in the access cycle |
| reg_fault | output | 1 | Access blocked by the guard bit |
| fetch_valid | input | 1 | An instruction fetch is presented |
| fetch_addr | input | 32 | Linear address of the instruction start |
| exec_fault | output | 1 | Execute breakpoint fault request |
| mem_valid | input | 1 | A data access is presented |
| mem_write | input | 1 | 1 = write access |
| mem_addr | input | 32 | Linear address of the data access |
| mem_size | input | 2 | Access size code (00/01/11) |
| retire | input | 1 | The current instruction completes |
| data_trap | output | 1 | Data breakpoint trap request |
| task_sw | input | 1 | Task switch pulse |
| exc_entry | input | 1 | Debug handler entry pulse |

## Verification
The bench goes after the edges of the overlap rule: accesses one byte outside a region, and a wide access over a narrow breakpoint. A compare that masked only by the breakpoint length would miss the second case, and one that ignored the length would hit the first. It checks that a write-only slot stays silent on reads and that a reserved qualifier never fires. It checks that an execute slot with a 4-byte length still matches only its exact start byte. It checks the one-retire delay when neither exact bit is set; a design that always reported at once would fail there. It checks that a guarded write leaves the address untouched, that handler entry releases the guard, and that a task switch removes only the local enables. A design that cleared the wrong set would drop global breakpoints in that case.

// File: rtl/bkpt_pkg.sv
package bkpt_pkg;
  localparam int unsigned ADDR_W = 32;

  typedef enum logic [1:0] {
    Q_EXEC  = 2'b00,
    Q_WRITE = 2'b01,
    Q_RSVD  = 2'b10,
    Q_RW    = 2'b11
  } qual_e;

  // low address bits ignored for a length/size code
  function automatic logic [1:0] low_mask(input logic [1:0] code);
    case (code)
      2'b00:   return 2'b00;
      2'b01:   return 2'b01;
      default: return 2'b11;
    endcase
  endfunction

  // aligned regions overlap when addresses agree above the larger span
  function automatic logic region_hit(input logic [ADDR_W-1:0] bp,
                                      input logic [1:0] len,
                                      input logic [ADDR_W-1:0] acc,
                                      input logic [1:0] size);
    logic [1:0] m;
    m = low_mask(len) | low_mask(size);
    return ((bp ^ acc) & ~{{(ADDR_W-2){1'b0}}, m}) == '0;
  endfunction

  function automatic logic data_qual_ok(input qual_e q, input logic is_write);
    case (q)
      Q_WRITE: return is_write;
      Q_RW:    return 1'b1;
      default: return 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/bkpt_slot.sv
module bkpt_slot import bkpt_pkg::*; (
  input  logic [ADDR_W-1:0] bp_addr,
  input  logic [1:0]        len_code,
  input  logic [1:0]        qual_code,
  input  logic              fetch_valid,
  input  logic [ADDR_W-1:0] fetch_addr,
  input  logic              mem_valid,
  input  logic              mem_write,
  input  logic [ADDR_W-1:0] mem_addr,
  input  logic [1:0]        mem_size,
  output logic              exec_hit,
  output logic              data_hit
);
  qual_e q;
  assign q = qual_e'(qual_code);

  // execute compare is byte exact; the length field plays no part
  assign exec_hit = fetch_valid && (q == Q_EXEC) && (fetch_addr == bp_addr);
  assign data_hit = mem_valid && data_qual_ok(q, mem_write) &&
                    region_hit(bp_addr, len_code, mem_addr, mem_size);
endmodule

// File: rtl/bkpt_regs.sv
module bkpt_regs import bkpt_pkg::*; #(
  parameter int unsigned NSLOT = 4,
  parameter int unsigned DW    = 32,
  localparam int unsigned SELW = $clog2(NSLOT + 2),
  localparam int unsigned CW   = 8 * NSLOT
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         reg_en,
  input  logic                         reg_wr,
  input  logic [SELW-1:0]              reg_sel,
  input  logic [DW-1:0]                reg_wdata,
  output logic [DW-1:0]                reg_rdata,
  input  logic                         task_sw,
  input  logic                         exc_entry,
  input  logic [NSLOT-1:0]             hit_set,
  output logic [NSLOT-1:0][ADDR_W-1:0] bp_addr,
  output logic [NSLOT-1:0]             loc_en,
  output logic [NSLOT-1:0]             glb_en,
  output logic                         lx,
  output logic                         gx,
  output logic                         guard,
  output logic [2*NSLOT-1:0]           qual_vec,
  output logic [2*NSLOT-1:0]           len_vec
);
  localparam int unsigned LX_BIT    = 2 * NSLOT;
  localparam int unsigned GX_BIT    = 2 * NSLOT + 1;
  localparam int unsigned GUARD_BIT = 2 * NSLOT + 5;
  localparam int unsigned QUAL_LSB  = 4 * NSLOT;
  localparam int unsigned LEN_LSB   = 6 * NSLOT;
  localparam int unsigned CTRL_SEL  = NSLOT;
  localparam int unsigned STAT_SEL  = NSLOT + 1;
  localparam logic [CW-1:0] LOCAL_MASK =
    (CW'(1) << LX_BIT) | ((CW'(1) << NSLOT) - CW'(1));

  logic [CW-1:0]    ctrl_q, ctrl_d;
  logic [NSLOT-1:0] hits_q, hits_d;
  logic             access_ok, wr_ok;

  assign access_ok = reg_en && !ctrl_q[GUARD_BIT];
  assign wr_ok     = access_ok && reg_wr;

  always_comb begin
    ctrl_d = ctrl_q;
    if (wr_ok && reg_sel == SELW'(CTRL_SEL)) ctrl_d = reg_wdata[CW-1:0];
    if (task_sw)   ctrl_d = ctrl_d & ~LOCAL_MASK;
    if (exc_entry) ctrl_d[GUARD_BIT] = 1'b0;
  end

  always_comb begin
    hits_d = hits_q;
    if (wr_ok && reg_sel == SELW'(STAT_SEL)) hits_d = hits_q & reg_wdata[NSLOT-1:0];
    hits_d = hits_d | hit_set;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      hits_q <= '0;
    end else begin
      ctrl_q <= ctrl_d;
      hits_q <= hits_d;
    end
  end

  for (genvar i = 0; i < NSLOT; i++) begin : g_addr
    always_ff @(posedge clk) begin
      if (!rst_n) bp_addr[i] <= '0;
      else if (wr_ok && reg_sel == SELW'(i)) bp_addr[i] <= reg_wdata[ADDR_W-1:0];
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (access_ok) begin
      for (int i = 0; i < NSLOT; i++)
        if (reg_sel == SELW'(i)) reg_rdata = DW'(bp_addr[i]);
      if (reg_sel == SELW'(CTRL_SEL)) reg_rdata = DW'(ctrl_q);
      if (reg_sel == SELW'(STAT_SEL)) reg_rdata = DW'(hits_q);
    end
  end

  assign loc_en   = ctrl_q[NSLOT-1:0];
  assign glb_en   = ctrl_q[2*NSLOT-1:NSLOT];
  assign lx       = ctrl_q[LX_BIT];
  assign gx       = ctrl_q[GX_BIT];
  assign guard    = ctrl_q[GUARD_BIT];
  assign qual_vec = ctrl_q[QUAL_LSB +: 2*NSLOT];
  assign len_vec  = ctrl_q[LEN_LSB +: 2*NSLOT];
endmodule

// File: rtl/bkpt_trap.sv
module bkpt_trap #(
  parameter int unsigned NSLOT = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NSLOT-1:0] armed_hits,
  input  logic             retire,
  input  logic             exact,
  output logic             data_trap
);
  logic pending_q, deferred_q, cur;

  // matches gathered over the instruction now in flight
  assign cur       = pending_q || (|armed_hits);
  assign data_trap = retire && (exact ? cur : deferred_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pending_q  <= 1'b0;
      deferred_q <= 1'b0;
    end else if (retire) begin
      pending_q  <= 1'b0;
      deferred_q <= exact ? 1'b0 : cur;
    end else begin
      pending_q  <= cur;
    end
  end
endmodule

// File: rtl/bkpt_unit.sv
module bkpt_unit import bkpt_pkg::*; #(
  parameter int unsigned NSLOT = 4,
  parameter int unsigned DW    = 32,
  localparam int unsigned SELW = $clog2(NSLOT + 2)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_en,
  input  logic              reg_wr,
  input  logic [SELW-1:0]   reg_sel,
  input  logic [DW-1:0]     reg_wdata,
  output logic [DW-1:0]     reg_rdata,
  output logic              reg_fault,
  input  logic              fetch_valid,
  input  logic [ADDR_W-1:0] fetch_addr,
  output logic              exec_fault,
  input  logic              mem_valid,
  input  logic              mem_write,
  input  logic [ADDR_W-1:0] mem_addr,
  input  logic [1:0]        mem_size,
  input  logic              retire,
  output logic              data_trap,
  input  logic              task_sw,
  input  logic              exc_entry
);
  logic [NSLOT-1:0][ADDR_W-1:0] bp_addr;
  logic [NSLOT-1:0]             loc_en, glb_en, slot_on;
  logic                         lx, gx, guard;
  logic [2*NSLOT-1:0]           qual_vec, len_vec;
  logic [NSLOT-1:0]             exec_hits, data_hits;

  bkpt_regs #(.NSLOT(NSLOT), .DW(DW)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_en    (reg_en),
    .reg_wr    (reg_wr),
    .reg_sel   (reg_sel),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .task_sw   (task_sw),
    .exc_entry (exc_entry),
    .hit_set   (exec_hits | data_hits),
    .bp_addr   (bp_addr),
    .loc_en    (loc_en),
    .glb_en    (glb_en),
    .lx        (lx),
    .gx        (gx),
    .guard     (guard),
    .qual_vec  (qual_vec),
    .len_vec   (len_vec)
  );

  for (genvar i = 0; i < NSLOT; i++) begin : g_slot
    bkpt_slot u_slot (
      .bp_addr     (bp_addr[i]),
      .len_code    (len_vec[2*i +: 2]),
      .qual_code   (qual_vec[2*i +: 2]),
      .fetch_valid (fetch_valid),
      .fetch_addr  (fetch_addr),
      .mem_valid   (mem_valid),
      .mem_write   (mem_write),
      .mem_addr    (mem_addr),
      .mem_size    (mem_size),
      .exec_hit    (exec_hits[i]),
      .data_hit    (data_hits[i])
    );
  end

  assign slot_on    = loc_en | glb_en;
  assign reg_fault  = reg_en && guard;
  assign exec_fault = |(exec_hits & slot_on);

  bkpt_trap #(.NSLOT(NSLOT)) u_trap (
    .clk        (clk),
    .rst_n      (rst_n),
    .armed_hits (data_hits & slot_on),
    .retire     (retire),
    .exact      (lx || gx),
    .data_trap  (data_trap)
  );
endmodule

// File: rtl/bkpt_unit_chk.sv
module bkpt_unit_chk #(
  parameter int unsigned NSLOT = 4,
  localparam int unsigned SELW = $clog2(NSLOT + 2)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             reg_en,
  input logic             reg_wr,
  input logic [SELW-1:0]  reg_sel,
  input logic             reg_fault,
  input logic             fetch_valid,
  input logic             exec_fault,
  input logic             retire,
  input logic             data_trap,
  input logic             task_sw,
  input logic             exc_entry,
  input logic [NSLOT-1:0] loc_en,
  input logic [NSLOT-1:0] glb_en,
  input logic             lx,
  input logic             gx,
  input logic             guard
);
  logic ctrl_write;
  assign ctrl_write = reg_en && reg_wr && !reg_fault && reg_sel == SELW'(NSLOT);

  p_exec_needs_fetch_r3: assert property (@(posedge clk) disable iff (!rst_n)
    exec_fault |-> fetch_valid);

  p_trap_on_retire_r10: assert property (@(posedge clk) disable iff (!rst_n)
    data_trap |-> retire);

  p_fault_needs_access_r8: assert property (@(posedge clk) disable iff (!rst_n)
    reg_fault |-> reg_en);

  p_guarded_write_dropped_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_fault && reg_wr && !task_sw && !exc_entry) |=>
      ($stable(loc_en) && $stable(glb_en) && guard));

  p_entry_clears_guard_r8: assert property (@(posedge clk) disable iff (!rst_n)
    exc_entry |=> !guard);

  p_task_clears_local_r9: assert property (@(posedge clk) disable iff (!rst_n)
    task_sw |=> (loc_en == '0 && !lx));

  p_task_keeps_global_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (task_sw && !ctrl_write) |=> ($stable(glb_en) && $stable(gx)));
endmodule

bind bkpt_unit bkpt_unit_chk #(.NSLOT(NSLOT)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .reg_en      (reg_en),
  .reg_wr      (reg_wr),
  .reg_sel     (reg_sel),
  .reg_fault   (reg_fault),
  .fetch_valid (fetch_valid),
  .exec_fault  (exec_fault),
  .retire      (retire),
  .data_trap   (data_trap),
  .task_sw     (task_sw),
  .exc_entry   (exc_entry),
  .loc_en      (loc_en),
  .glb_en      (glb_en),
  .lx          (lx),
  .gx          (gx),
  .guard       (guard)
);

// File: tb/bkpt_unit_bench.sv
`timescale 1ns/1ps
module bkpt_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_en = 0, reg_wr = 0;
  logic [2:0]  reg_sel = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        reg_fault;
  logic        fetch_valid = 0;
  logic [31:0] fetch_addr = '0;
  logic        exec_fault;
  logic        mem_valid = 0, mem_write = 0;
  logic [31:0] mem_addr = '0;
  logic [1:0]  mem_size = '0;
  logic        retire = 0, data_trap;
  logic        task_sw = 0, exc_entry = 0;

  int checks = 0;
  int errors = 0;
  logic last_fault;

  always #5 clk = ~clk;

  bkpt_unit u_bkpt_unit (
    .clk(clk), .rst_n(rst_n), .reg_en(reg_en), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .reg_fault(reg_fault),
    .fetch_valid(fetch_valid), .fetch_addr(fetch_addr), .exec_fault(exec_fault),
    .mem_valid(mem_valid), .mem_write(mem_write), .mem_addr(mem_addr), .mem_size(mem_size),
    .retire(retire), .data_trap(data_trap), .task_sw(task_sw), .exc_entry(exc_entry)
  );

  // {addr, size, write, expected status}; slots: 0x1000/1B/rw, 0x2002/2B/wr,
  // 0x3004/4B/rw (disabled), 0x4000/4B/reserved qualifier
  localparam logic [38:0] VEC [12] = '{
    {32'h0000_1000, 2'b00, 1'b0, 4'b0001},
    {32'h0000_1001, 2'b00, 1'b1, 4'b0000},
    {32'h0000_1000, 2'b11, 1'b0, 4'b0001},
    {32'h0000_2002, 2'b01, 1'b0, 4'b0000},
    {32'h0000_2003, 2'b00, 1'b1, 4'b0010},
    {32'h0000_2000, 2'b11, 1'b1, 4'b0010},
    {32'h0000_2004, 2'b01, 1'b1, 4'b0000},
    {32'h0000_3007, 2'b00, 1'b0, 4'b0100},
    {32'h0000_3008, 2'b00, 1'b1, 4'b0000},
    {32'h0000_4001, 2'b00, 1'b1, 4'b0000},
    {32'h0000_3006, 2'b01, 1'b1, 4'b0100},
    {32'h0000_1002, 2'b01, 1'b1, 4'b0000}
  };

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic reg_write(input logic [2:0] sel, input logic [31:0] d);
    @(negedge clk);
    reg_en = 1; reg_wr = 1; reg_sel = sel; reg_wdata = d;
    #1 last_fault = reg_fault;
    @(posedge clk); #1;
    reg_en = 0; reg_wr = 0;
  endtask

  task automatic reg_read(input logic [2:0] sel, output logic [31:0] d);
    @(negedge clk);
    reg_en = 1; reg_wr = 0; reg_sel = sel;
    #1 d = reg_rdata; last_fault = reg_fault;
    @(posedge clk); #1;
    reg_en = 0;
  endtask

  task automatic mem_access(input logic [31:0] a, input logic [1:0] sz, input logic wr);
    @(negedge clk);
    mem_valid = 1; mem_addr = a; mem_size = sz; mem_write = wr;
    @(posedge clk); #1;
    mem_valid = 0; mem_write = 0;
  endtask

  task automatic retire_once(output logic t);
    @(negedge clk);
    retire = 1;
    #1 t = data_trap;
    @(posedge clk); #1;
    retire = 0;
  endtask

  task automatic fetch_once(input logic [31:0] a, output logic f);
    @(negedge clk);
    fetch_valid = 1; fetch_addr = a;
    #1 f = exec_fault;
    @(posedge clk); #1;
    fetch_valid = 0;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    $display("FAIL R1 watchdog actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] d;
    logic t;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;

    // R1: reset state
    for (int s = 0; s < 6; s++) begin
      reg_read(3'(s), d);
      check("R1", "reset register", d, 32'h0);
    end
    check("R1", "outputs idle", {29'h0, exec_fault, data_trap, reg_fault}, 32'h0);

    // R2 / R11: program slots and control
    reg_write(3'd0, 32'h0000_1000);
    reg_write(3'd1, 32'h0000_2002);
    reg_write(3'd2, 32'h0000_3004);
    reg_write(3'd3, 32'h0000_4000);
    reg_write(3'd4, 32'hF4B7_0092);
    reg_read(3'd0, d); check("R2", "slot0 addr", d, 32'h0000_1000);
    reg_read(3'd1, d); check("R2", "slot1 addr", d, 32'h0000_2002);
    reg_read(3'd2, d); check("R2", "slot2 addr", d, 32'h0000_3004);
    reg_read(3'd3, d); check("R2", "slot3 addr", d, 32'h0000_4000);
    reg_read(3'd4, d); check("R2", "control", d, 32'hF4B7_0092);
    reg_read(3'd6, d); check("R2", "unmapped select", d, 32'h0);

    // R4 R5 R11: overlap and qualifier table
    foreach (VEC[k]) begin
      reg_write(3'd5, 32'h0);
      mem_access(VEC[k][38:7], VEC[k][6:5], VEC[k][4]);
      reg_read(3'd5, d);
      check("R4_R5", $sformatf("vector %0d status", k), d, {28'h0, VEC[k][3:0]});
    end

    // R10 R6: non-exact data trap is one retire late
    reg_write(3'd5, 32'h0);
    mem_access(32'h0000_2002, 2'b00, 1'b1);
    retire_once(t); check("R10", "non-exact first retire", {31'h0, t}, 32'h0);
    retire_once(t); check("R6", "local-enabled slot traps late", {31'h0, t}, 32'h1);
    retire_once(t); check("R10", "trap not repeated", {31'h0, t}, 32'h0);

    // R10: exact bit reports on the same retire
    reg_write(3'd4, 32'hF4B7_0292);
    mem_access(32'h0000_1000, 2'b00, 1'b0);
    retire_once(t); check("R10", "exact trap on retire", {31'h0, t}, 32'h1);

    // R6 R7: disabled slot records status but never traps
    mem_access(32'h0000_3004, 2'b00, 1'b0);
    retire_once(t); check("R6", "disabled slot no trap", {31'h0, t}, 32'h0);
    retire_once(t); check("R6", "disabled slot no late trap", {31'h0, t}, 32'h0);
    reg_read(3'd5, d); check("R7", "status incl disabled", d, 32'h7);

    // R7: sticky clear semantics
    reg_write(3'd5, 32'hF);
    reg_read(3'd5, d); check("R7", "ones keep status", d, 32'h7);
    reg_write(3'd5, 32'h5);
    reg_read(3'd5, d); check("R7", "zero clears bit", d, 32'h5);
    reg_write(3'd5, 32'h0);
    reg_read(3'd5, d); check("R7", "all cleared", d, 32'h0);

    // R3: slot0 as execute with 4-byte length code
    reg_write(3'd4, 32'hF7B4_0292);
    fetch_once(32'h0000_1000, t); check("R3", "exec exact match", {31'h0, t}, 32'h1);
    fetch_once(32'h0000_1001, t); check("R3", "exec length ignored", {31'h0, t}, 32'h0);
    fetch_once(32'h0000_2002, t); check("R3", "write slot no exec", {31'h0, t}, 32'h0);
    mem_access(32'h0000_1000, 2'b00, 1'b0);
    retire_once(t); check("R5", "exec slot no data trap", {31'h0, t}, 32'h0);

    // R9: task switch
    reg_write(3'd4, 32'hF7B4_0392);
    @(negedge clk); task_sw = 1;
    @(posedge clk); #1 task_sw = 0;
    reg_read(3'd4, d); check("R9", "local bits cleared", d, 32'hF7B4_0290);
    mem_access(32'h0000_2002, 2'b00, 1'b1);
    retire_once(t); check("R9", "local slot silenced", {31'h0, t}, 32'h0);

    // R8: guard
    reg_write(3'd4, 32'hF7B4_2290);
    reg_read(3'd4, d);
    check("R8", "guarded read data", d, 32'h0);
    check("R8", "guarded read fault", {31'h0, last_fault}, 32'h1);
    reg_write(3'd0, 32'hDEAD_0000);
    check("R8", "guarded write fault", {31'h0, last_fault}, 32'h1);
    @(negedge clk); exc_entry = 1;
    @(posedge clk); #1 exc_entry = 0;
    reg_read(3'd0, d); check("R8", "guarded write ignored", d, 32'h0000_1000);
    check("R8", "fault gone after entry", {31'h0, last_fault}, 32'h0);
    reg_read(3'd4, d); check("R8", "guard cleared", d, 32'hF7B4_0290);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule